// File: doc/BRIEF.md
# Power-Up Self-Test Sequencer

This controller sits in front of a block of cipher and hash datapaths and proves them correct after every reset before anything else may use them. Once reset is released it works through ten known-answer tests on its own, with no software command. For each test it sends a one-cycle start pulse and a test number to the engine port. It waits for the engine's done pulse and checks the returned result window against a constant it computes itself. Only the bits that belong to that test's output width are compared.

While the tests run, the external data-in and data-out valid paths and the service-request acknowledge are held low. When all ten tests pass, the block reports ready and opens these paths. A wrong result, or a done pulse that never arrives before a cycle limit, sends the block into a latched failure state. In that state the paths stay shut and only the number of the failing test is reported. Neither the result data nor any key material appears on a status output. The only way out is a reset, which runs the whole series again from the first test.

The test numbers follow a fixed order:

| Index | Test |
|-------|------|
| 0 | AES-256 CCM encrypt |
| 1 | AES-256 CCM decrypt |
| 2 | AES-256 ECB encrypt |
| 3 | AES-256 ECB decrypt |
| 4 | HMAC-SHA-1 with a 512-bit key |
| 5 | HMAC-SHA-256 |
| 6 | HMAC-SHA-384 |
| 7 | HMAC-SHA-512 |
| 8 | AES-256 CMAC generate |
| 9 | AES-256 CMAC verify |

Top module: `selftest_seq`

## Requirements
- R1: After rst_n is released, the block issues its first start pulse, with eng_index = 0, within four clock cycles and without any command. While rst_n is low, busy = 1, ready = 0, failed = 0, fail_index = 0 and eng_start = 0.
- R2: Tests are started in index order 0, 1, 2 … 9. Each test gets exactly one one-cycle eng_start pulse. The next test starts only after the current one has returned a matching result.
- R3: A result is compared only over its low W bits. W is 128 for indices 0-3, 8 and 9; 160 for index 4; 256 for index 5; 384 for index 6; 512 for index 7. Bits at position W and above are ignored.
- R4: The expected value for test k is the 32-bit word 0x5A5A0000 + k × 0x00010111, repeated across the 512-bit window and then cut to W bits.
- R5: A mismatch on test k sets failed = 1, ready = 0, busy = 0 and fail_index = k. fail_index is the only failure detail that is output, and no further start pulse is issued.
- R6: If no done pulse arrives within TIMEOUT_CYCLES cycles of waiting after a start, the test counts as failed, with fail_index set to that test's number. A done pulse that arrives earlier is accepted.
- R7: While busy, core_in_valid, ext_out_valid and svc_accept are 0 whatever ext_in_valid, core_out_valid and svc_req carry.
- R8: In the failure state those three outputs stay 0. Done pulses have no effect, and failed and fail_index hold until reset.
- R9: A reset taken from the failure state reruns all ten tests from index 0, clears fail_index to 0, and reaches ready only if all ten pass.
- R10: ready rises only after test 9 passes. While ready, core_in_valid follows ext_in_valid, ext_out_valid follows core_out_valid and svc_accept follows svc_req. A stray done pulse leaves ready set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| eng_start | output | 1 | One-cycle request to run a test |
| eng_index | output | 4 | Number of the test being requested |
| eng_done | input | 1 | One-cycle completion from the engines |
| eng_result | input | 512 | Result window returned with eng_done |
| ext_in_valid | input | 1 | Valid of data arriving from outside |
| core_in_valid | output | 1 | Gated valid toward the datapaths |
| core_out_valid | input | 1 | Valid of data leaving the datapaths |
| ext_out_valid | output | 1 | Gated valid toward the outside |
| svc_req | input | 1 | Service request from a caller |
| svc_accept | output | 1 | Service request accepted |
| busy | output | 1 | Self-test series in progress |
| ready | output | 1 | All tests passed, services open |
| failed | output | 1 | Latched failure state |
| fail_index | output | 4 | Number of the test that failed, else 0 |

## Verification
The bench builds the block with TIMEOUT_CYCLES = 64 instead of 4096. At that value a missing done pulse expires in a few dozen cycles, so timeouts at the first and the last test fit beside the mismatch cases. An engine latency of 60 cycles lands just inside the limit and checks that a slow but valid answer is still accepted. The 512-bit result window is kept at full width, so corruptions at the top bit of each output width and one bit above it exercise the masking edges of R3.

// File: rtl/selftest_pkg.sv
package selftest_pkg;
  localparam int NUM_TESTS = 10;
  localparam int RES_W     = 512;
  localparam int WORD_W    = 32;
  localparam int IDX_W     = $clog2(NUM_TESTS);
  localparam int WID_W     = $clog2(RES_W + 1);
  localparam logic [WORD_W-1:0] EXP_BASE = 32'h5A5A0000;
  localparam logic [WORD_W-1:0] EXP_STEP = 32'h00010111;

  typedef enum logic [2:0] {
    S_BOOT, S_ISSUE, S_WAIT, S_PASS, S_FAIL
  } st_state_e;

  // Output width in bits of each test, in run order.
  function automatic logic [WID_W-1:0] test_width(input logic [IDX_W-1:0] k);
    case (k)
      4'd4:    test_width = WID_W'(160);
      4'd5:    test_width = WID_W'(256);
      4'd6:    test_width = WID_W'(384);
      4'd7:    test_width = WID_W'(512);
      default: test_width = WID_W'(128);
    endcase
  endfunction

  function automatic logic [RES_W-1:0] test_expect(input logic [IDX_W-1:0] k);
    logic [WORD_W-1:0] w;
    logic [RES_W-1:0]  v;
    w = EXP_BASE + WORD_W'(k) * EXP_STEP;
    for (int i = 0; i < RES_W / WORD_W; i++) v[i*WORD_W +: WORD_W] = w;
    return v;
  endfunction
endpackage

// File: rtl/st_rst_sync.sv
module st_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/st_timer.sv
module st_timer #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expired = run && (cnt_q == CW'(LIMIT - 1));
  assign cnt_en  = clear || (run && !expired);

  always_comb begin
    if (clear) cnt_d = '0;
    else       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/st_compare.sv
module st_compare
  import selftest_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  input  logic [RES_W-1:0] result,
  output logic             match
);
  logic [RES_W-1:0] mask;
  logic [RES_W-1:0] expect_v;

  always_comb begin
    // A width equal to RES_W shifts every one out, leaving a full mask.
    mask     = ~({RES_W{1'b1}} << test_width(idx));
    expect_v = test_expect(idx);
    match    = ((result ^ expect_v) & mask) == '0;
  end
endmodule

// File: rtl/st_gate.sv
module st_gate (
  input  logic open,
  input  logic ext_in_valid,
  output logic core_in_valid,
  input  logic core_out_valid,
  output logic ext_out_valid,
  input  logic svc_req,
  output logic svc_accept
);
  assign core_in_valid = open && ext_in_valid;
  assign ext_out_valid = open && core_out_valid;
  assign svc_accept    = open && svc_req;
endmodule

// File: rtl/selftest_seq.sv
module selftest_seq
  import selftest_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             eng_start,
  output logic [IDX_W-1:0] eng_index,
  input  logic             eng_done,
  input  logic [RES_W-1:0] eng_result,
  input  logic             ext_in_valid,
  output logic             core_in_valid,
  input  logic             core_out_valid,
  output logic             ext_out_valid,
  input  logic             svc_req,
  output logic             svc_accept,
  output logic             busy,
  output logic             ready,
  output logic             failed,
  output logic [IDX_W-1:0] fail_index
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_TESTS - 1);

  logic             rst_n_i;
  st_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] fidx_q, fidx_d;
  logic             idx_en, fidx_en;
  logic             match, expired;

  st_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  st_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n_i),
    .clear(state_q == S_ISSUE), .run(state_q == S_WAIT),
    .expired(expired)
  );

  st_compare u_cmp (.idx(idx_q), .result(eng_result), .match(match));

  st_gate u_gate (
    .open(state_q == S_PASS),
    .ext_in_valid(ext_in_valid), .core_in_valid(core_in_valid),
    .core_out_valid(core_out_valid), .ext_out_valid(ext_out_valid),
    .svc_req(svc_req), .svc_accept(svc_accept)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q + 1'b1;
    idx_en  = 1'b0;
    fidx_d  = idx_q;
    fidx_en = 1'b0;
    case (state_q)
      S_BOOT:  state_d = S_ISSUE;
      S_ISSUE: state_d = S_WAIT;
      S_WAIT: begin
        if (eng_done) begin
          if (!match) begin
            state_d = S_FAIL;
            fidx_en = 1'b1;
          end else if (idx_q == LAST_IDX) begin
            state_d = S_PASS;
          end else begin
            state_d = S_ISSUE;
            idx_en  = 1'b1;
          end
        end else if (expired) begin
          state_d = S_FAIL;
          fidx_en = 1'b1;
        end
      end
      default: state_d = state_q;  // S_PASS and S_FAIL hold until reset
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= S_BOOT;
      idx_q   <= '0;
      fidx_q  <= '0;
    end else begin
      state_q <= state_d;
      if (idx_en)  idx_q  <= idx_d;
      if (fidx_en) fidx_q <= fidx_d;
    end
  end

  assign eng_start  = (state_q == S_ISSUE);
  assign eng_index  = idx_q;
  assign ready      = (state_q == S_PASS);
  assign failed     = (state_q == S_FAIL);
  assign busy       = !ready && !failed;
  assign fail_index = fidx_q;
endmodule

// File: rtl/selftest_seq_chk.sv
module selftest_seq_chk
  import selftest_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             eng_start,
  input logic [IDX_W-1:0] eng_index,
  input logic             core_in_valid,
  input logic             ext_out_valid,
  input logic             svc_accept,
  input logic             ready,
  input logic             failed,
  input logic [IDX_W-1:0] fail_index
);
  // R2: a start request lasts exactly one cycle
  p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  // R2: the index cannot change while the request is raised
  p_index_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> $stable(eng_index));

  // R7: nothing passes the gate until the series has passed
  p_gate_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !core_in_valid && !ext_out_valid && !svc_accept);

  // R5: passed and failed never coexist
  p_status_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ready, failed}));

  // R8: the failure state and its index persist until reset
  p_fail_latched_r8: assert property (@(posedge clk) disable iff (!rst_n)
    failed |=> failed && $stable(fail_index));

  // R8: no test is requested once failed
  p_fail_no_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    failed |-> !eng_start);

  // R10: ready holds once reached
  p_ready_latched_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
endmodule

bind selftest_seq selftest_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .eng_start(eng_start), .eng_index(eng_index),
  .core_in_valid(core_in_valid), .ext_out_valid(ext_out_valid),
  .svc_accept(svc_accept), .ready(ready), .failed(failed),
  .fail_index(fail_index)
);

// File: tb/test_selftest_seq.sv
module test_selftest_seq;
  localparam int TMO = 64;
  localparam int NSCN = 9;

  logic         clk;
  logic         rst_n;
  logic         eng_start;
  logic [3:0]   eng_index;
  logic         eng_done;
  logic [511:0] eng_result;
  logic         ext_in_valid, core_in_valid, core_out_valid, ext_out_valid;
  logic         svc_req, svc_accept;
  logic         busy, ready, failed;
  logic [3:0]   fail_index;

  int checks = 0;
  int fails  = 0;

  // stub engine controls
  int  lat;
  int  corrupt_idx, corrupt_bit, drop_idx;
  bit  garbage, force_done;
  int  nstarts;
  int  seq [16];
  bit  pend;
  int  cnt, cur;

  selftest_seq #(.TIMEOUT_CYCLES(TMO)) i_selftest_seq (
    .clk(clk), .rst_n(rst_n), .eng_start(eng_start), .eng_index(eng_index),
    .eng_done(eng_done), .eng_result(eng_result),
    .ext_in_valid(ext_in_valid), .core_in_valid(core_in_valid),
    .core_out_valid(core_out_valid), .ext_out_valid(ext_out_valid),
    .svc_req(svc_req), .svc_accept(svc_accept),
    .busy(busy), .ready(ready), .failed(failed), .fail_index(fail_index)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int ref_width(int k);
    case (k)
      4: return 160;
      5: return 256;
      6: return 384;
      7: return 512;
      default: return 128;
    endcase
  endfunction

  function automatic logic [511:0] ref_val(int k, bit garb);
    logic [31:0]  w;
    logic [511:0] v;
    w = 32'h5A5A0000 + 32'(k) * 32'h00010111;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = w;
    for (int b = 0; b < 512; b++)
      if (b >= ref_width(k)) v[b] = garb ? ~v[b] : v[b];
    return v;
  endfunction

  // Behavioural engine stub, acting on the falling edge
  always @(negedge clk) begin
    eng_done = 1'b0;
    if (!rst_n) begin
      pend = 1'b0;
    end else if (force_done) begin
      eng_done   = 1'b1;
      eng_result = ref_val(0, 1'b0);
      force_done = 1'b0;
    end else if (eng_start) begin
      if (nstarts < 16) seq[nstarts] = int'(eng_index);
      nstarts = nstarts + 1;
      pend = 1'b1;
      cnt  = lat;
      cur  = int'(eng_index);
    end else if (pend) begin
      cnt = cnt - 1;
      if (cnt == 0) begin
        pend = 1'b0;
        if (cur != drop_idx) begin
          eng_done   = 1'b1;
          eng_result = ref_val(cur, garbage);
          if (cur == corrupt_idx) eng_result[corrupt_bit] = ~eng_result[corrupt_bit];
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic apply_reset();
    @(posedge clk); #2;
    rst_n   = 1'b0;
    nstarts = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #2;
      if (ready || failed) break;
    end
  endtask

  // scenario: {corrupt_idx[4], corrupt_bit[10], drop_idx[4], garbage, exp_fail, exp_idx[4]}
  localparam logic [23:0] SCN [NSCN] = '{
    {4'd15, 10'd0,   4'd15, 1'b0, 1'b0, 4'd0},  // clean run (R2, R4, R10)
    {4'd15, 10'd0,   4'd15, 1'b1, 1'b0, 4'd0},  // inverted bits above width (R3)
    {4'd0,  10'd0,   4'd15, 1'b0, 1'b1, 4'd0},  // first test bad (R5)
    {4'd4,  10'd159, 4'd15, 1'b0, 1'b1, 4'd4},  // top bit of 160 (R3, R5)
    {4'd4,  10'd160, 4'd15, 1'b0, 1'b0, 4'd0},  // first masked bit (R3)
    {4'd9,  10'd127, 4'd15, 1'b0, 1'b1, 4'd9},  // last test bad (R5)
    {4'd7,  10'd511, 4'd15, 1'b0, 1'b1, 4'd7},  // top of full window (R3)
    {4'd15, 10'd0,   4'd3,  1'b0, 1'b1, 4'd3},  // missing done (R6)
    {4'd15, 10'd0,   4'd9,  1'b0, 1'b1, 4'd9}   // missing done at end (R6)
  };

  initial begin
    rst_n = 1'b0; ext_in_valid = 0; core_out_valid = 0; svc_req = 0;
    eng_done = 0; eng_result = '0; force_done = 0; lat = 3; nstarts = 0;
    corrupt_idx = 15; corrupt_bit = 0; drop_idx = 15; garbage = 0;
    pend = 0; cnt = 0; cur = 0;

    // R1: reset state
    repeat (3) @(posedge clk); #2;
    chk(busy && !ready && !failed && fail_index == 0 && !eng_start, "R1",
        "reset status", {busy, ready, failed, eng_start}, 4'b1000);

    // R1: automatic start with index 0
    rst_n = 1'b1;
    begin
      bit seen = 0;
      int sidx = -1;
      for (int i = 0; i < 4; i++) begin
        @(posedge clk); #2;
        if (eng_start && !seen) begin seen = 1; sidx = int'(eng_index); end
      end
      chk(seen && sidx == 0, "R1", "first start index", sidx, 0);
    end

    // R7: gate closed while busy
    ext_in_valid = 1; core_out_valid = 1; svc_req = 1;
    @(posedge clk); #2;
    chk(busy && !core_in_valid && !ext_out_valid && !svc_accept, "R7",
        "gate while busy", {core_in_valid, ext_out_valid, svc_accept}, 0);
    wait_done();
    // R10: gate open once ready
    chk(ready && core_in_valid && ext_out_valid && svc_accept, "R10",
        "gate after pass", {ready, core_in_valid, ext_out_valid, svc_accept}, 4'b1111);
    ext_in_valid = 0; core_out_valid = 0; svc_req = 0;
    #1;
    chk(!core_in_valid && !ext_out_valid && !svc_accept, "R10",
        "gate follows inputs", {core_in_valid, ext_out_valid, svc_accept}, 0);
    // R10: stray done while ready
    force_done = 1;
    repeat (3) @(posedge clk); #2;
    chk(ready && !failed, "R10", "ready after stray done", ready, 1);

    // Scenario table
    for (int s = 0; s < NSCN; s++) begin
      logic [23:0] e;
      e = SCN[s];
      corrupt_idx = int'(e[23:20]);
      corrupt_bit = int'(e[19:10]);
      drop_idx    = int'(e[9:6]);
      garbage     = e[5];
      apply_reset();
      wait_done();
      repeat (20) @(posedge clk); #2;
      if (e[4]) begin
        chk(failed && !ready && !busy, "R5", $sformatf("scn%0d fail status", s),
            {failed, ready, busy}, 3'b100);
        chk(fail_index == e[3:0], "R5", $sformatf("scn%0d fail_index", s),
            fail_index, e[3:0]);
        chk(nstarts == int'(e[3:0]) + 1, "R8", $sformatf("scn%0d no start after fail", s),
            nstarts, int'(e[3:0]) + 1);
      end else begin
        chk(ready && !failed && fail_index == 0, "R3", $sformatf("scn%0d pass", s),
            {ready, failed}, 2'b10);
        chk(nstarts == 10, "R2", $sformatf("scn%0d start count", s), nstarts, 10);
        for (int k = 0; k < 10; k++)
          if (seq[k] != k) chk(1'b0, "R2", $sformatf("scn%0d order slot %0d", s, k), seq[k], k);
      end
    end

    // R6: slow but in-time answer passes
    corrupt_idx = 15; drop_idx = 15; garbage = 0; lat = 60;
    apply_reset();
    wait_done();
    chk(ready && !failed, "R6", "latency 60 accepted", ready, 1);
    lat = 3;

    // R8: failure state holds and ignores inputs
    corrupt_idx = 2; corrupt_bit = 5;
    apply_reset();
    wait_done();
    ext_in_valid = 1; core_out_valid = 1; svc_req = 1;
    force_done = 1;
    repeat (5) @(posedge clk); #2;
    chk(failed && fail_index == 2, "R8", "fail held after done", fail_index, 2);
    chk(!core_in_valid && !ext_out_valid && !svc_accept, "R8",
        "gate in fail", {core_in_valid, ext_out_valid, svc_accept}, 0);
    chk(nstarts == 3, "R8", "no restart in fail", nstarts, 3);

    // R9: reset from failure reruns everything
    corrupt_idx = 15;
    apply_reset();
    #1;
    chk(fail_index == 0 && !failed, "R9", "fail_index cleared", fail_index, 0);
    wait_done();
    chk(ready && nstarts == 10, "R9", "rerun to ready", nstarts, 10);
    chk(core_in_valid && svc_accept, "R9", "gate reopened", {core_in_valid, svc_accept}, 2'b11);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule